// File: doc/BRIEF.md
# I2C Combined-Transfer Message Sequencer

This block runs a list of I2C messages as one combined transfer on the bus. It reads each message's descriptor through an indexed port: a 7-bit target address, a direction flag, an address-bit inversion flag, a continue-without-start flag, a tolerate-missing-ACK flag and a byte count. It then sends one command at a time to a byte-level I2C engine. The commands are start-with-address, write a byte, read a byte while sending ACK or NAK, and stop. Each engine command completes with a one-cycle done pulse that carries the received acknowledge bit and any received byte.

Before the first start, the sequencer waits for the bus to go idle, within a bounded number of polls and attempts. It checks the acknowledge after the address byte and after read bytes. It chains messages with repeated starts, or continues straight on for write messages that ask for it. Read bytes are handed back through the same index port that supplies write data. At the end it pulses a done strobe together with an error code and a count of messages.

Top module: `i2c_msg_seq`

## Requirements
- R1: The byte sent with every start command is the message address in bits 7:1. Bit 0 is 1 for a read and 0 for a write, and it is inverted when the message's inversion flag is set.
- R2: If the engine reports no ACK after an address byte and the message's tolerate flag is clear, a stop follows and the transfer ends with error code 1. The count is then the index of the failing message.
- R3: A zero-length message that is last in the list gets a stop right after its address phase and counts as success. A zero-length message that is not last moves on to the next message.
- R4: A message without the continue flag begins with its own start command, a repeated start when it follows another message. A successful transfer ends with error code 0 and a count equal to the number of messages.
- R5: A write message with the continue flag that follows a finished message sends its bytes with no start command. A read message with the continue flag is rejected: a stop follows at once, with error code 3, and the count is that message's index.
- R6: Every read command asks the engine to send ACK (ack output 1). The one exception is the final byte of the final message, which is sent with NAK (ack output 0).
- R7: A read byte that is not the final byte of the transfer and comes back with a missing ACK aborts the transfer with a stop and error code 2. With the tolerate flag set, the transfer continues normally.
- R8: No start command is issued while the bus is busy. The block polls up to POLL_N cycles per attempt, for RETRY_N attempts. If the bus never clears it finishes with error code 4, count 0 and no engine command.
- R9: The done output is a single-cycle pulse. Except for a timeout, it appears in the same cycle as the stop command.
- R10: An engine completion that arrives while the sequencer is idle issues no command and raises no done, and it does not disturb the next transfer.
- R11: Each received read byte is presented on the read strobe in one cycle, indexed by the message number and the byte position within that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start a transfer (pulse while idle) |
| msg_count_i | input | IDX_W+1 | Number of messages in the list |
| bus_busy_i | input | 1 | Bus currently owned by another master |
| msg_sel_o | output | IDX_W | Index of the current message |
| byte_ptr_o | output | LEN_W | Byte position inside the current message |
| msg_addr_i | input | 7 | Descriptor: target address |
| msg_rd_i | input | 1 | Descriptor: read direction |
| msg_rev_i | input | 1 | Descriptor: invert direction bit of address byte |
| msg_nostart_i | input | 1 | Descriptor: continue without a start |
| msg_ignak_i | input | 1 | Descriptor: tolerate missing ACK |
| msg_len_i | input | LEN_W | Descriptor: byte count |
| wr_byte_i | input | 8 | Write data at the selected message/byte |
| rd_we_o | output | 1 | Received byte strobe |
| rd_byte_o | output | 8 | Received byte |
| eng_cmd_valid_o | output | 1 | Command strobe to the byte engine |
| eng_cmd_o | output | 2 | Command: 0 start, 1 write, 2 read, 3 stop |
| eng_byte_o | output | 8 | Address or data byte for the command |
| eng_ack_o | output | 1 | For reads: 1 send ACK, 0 send NAK |
| eng_done_i | input | 1 | Engine completed a command |
| eng_nak_i | input | 1 | Acknowledge bit was NAK |
| eng_rx_i | input | 8 | Byte received by a read |
| xfer_done_o | output | 1 | Transfer finished (one cycle) |
| xfer_err_o | output | 3 | 0 ok, 1 address NAK, 2 read NAK, 3 bad continuation, 4 bus timeout |
| xfer_count_o | output | IDX_W+1 | Messages finished, or index of the failing message |

## Verification
A wrong message index or byte pointer shows up within a single engine round trip. It appears as a wrong address byte on the next start command, a misplaced read strobe index, or a different number of commands before the stop. A state machine that takes the wrong branch after an acknowledge changes the command stream and the error code at the very next done pulse. A faulty busy poll changes how long the block takes to time out, or lets a start command through while the bus is busy. Each scenario compares the full command count, the error code and the message count with values worked out from the requirements.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_STOP  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_REMOTE  = 3'd1,
        ERR_REFUSED = 3'd2,
        ERR_INVAL   = 3'd3,
        ERR_TIMEOUT = 3'd4
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ARB, S_START, S_WRITE, S_READ, S_NEXT, S_STOP
    } st_e;

    typedef struct packed {
        logic [6:0]       addr;
        logic             rd;
        logic             rev;
        logic             nostart;
        logic             ignak;
        logic [LEN_W-1:0] len;
    } desc_t;

    typedef struct packed {
        logic       vld;
        cmd_e       kind;
        logic [7:0] data;
        logic       ack;
    } cmd_t;

    function automatic logic [7:0] addr_byte(desc_t d);
        return {d.addr, d.rd ^ d.rev};
    endfunction

endpackage

// File: rtl/i2c_seq_arb.sv
module i2c_seq_arb #(
    parameter int POLL_N  = 400,
    parameter int RETRY_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    input  logic busy,
    output logic grant,
    output logic expire
);
    localparam int PW = $clog2(POLL_N + 1);
    localparam int RW = $clog2(RETRY_N + 1);

    logic          active;
    logic [PW-1:0] polls;
    logic [RW-1:0] tries;
    logic          last_poll, last_try;

    assign last_poll = (polls == PW'(POLL_N - 1));
    assign last_try  = (tries == RW'(RETRY_N - 1));
    assign grant     = active && !busy;
    assign expire    = active && busy && last_poll && last_try;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            polls  <= '0;
            tries  <= '0;
        end else if (kick) begin
            active <= 1'b1;
            polls  <= '0;
            tries  <= '0;
        end else if (active) begin
            if (!busy) begin
                active <= 1'b0;
            end else if (last_poll) begin
                polls <= '0;
                if (last_try) active <= 1'b0;
                else          tries  <= tries + 1'b1;
            end else begin
                polls <= polls + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd
    import i2c_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  cmd_e       kind,
    input  desc_t      desc,
    input  logic [7:0] wdata,
    input  logic       ack,
    output cmd_t       cmd_q
);
    cmd_t nxt;

    always_comb begin
        nxt.vld  = issue;
        nxt.kind = kind;
        nxt.ack  = ack;
        unique case (kind)
            CMD_START: nxt.data = addr_byte(desc);
            CMD_WRITE: nxt.data = wdata;
            default:   nxt.data = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '{vld: 1'b0, kind: CMD_STOP, data: 8'h00, ack: 1'b1};
        else     cmd_q <= nxt;
    end

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_seq_pkg::*;
#(
    parameter int MSG_N   = 8,
    parameter int POLL_N  = 400,
    parameter int RETRY_N = 2,
    localparam int IDX_W  = $clog2(MSG_N),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [CNT_W-1:0] msg_count_i,
    input  logic             bus_busy_i,
    output logic [IDX_W-1:0] msg_sel_o,
    output logic [LEN_W-1:0] byte_ptr_o,
    input  logic [6:0]       msg_addr_i,
    input  logic             msg_rd_i,
    input  logic             msg_rev_i,
    input  logic             msg_nostart_i,
    input  logic             msg_ignak_i,
    input  logic [LEN_W-1:0] msg_len_i,
    input  logic [7:0]       wr_byte_i,
    output logic             rd_we_o,
    output logic [7:0]       rd_byte_o,
    output logic             eng_cmd_valid_o,
    output logic [1:0]       eng_cmd_o,
    output logic [7:0]       eng_byte_o,
    output logic             eng_ack_o,
    input  logic             eng_done_i,
    input  logic             eng_nak_i,
    input  logic [7:0]       eng_rx_i,
    output logic             xfer_done_o,
    output logic [2:0]       xfer_err_o,
    output logic [CNT_W-1:0] xfer_count_o
);
    st_e              state, st_n;
    logic [IDX_W-1:0] cur, cur_n;
    logic [LEN_W-1:0] ptr, ptr_n;
    err_e             err_q, err_n, fin_err, res_err;
    logic             done_q, fin;
    logic [CNT_W-1:0] fin_cnt, res_cnt;
    logic             iss, iss_ack, wstep, rstep, rd_we, last, final_byte;
    cmd_e             iss_kind;
    logic [LEN_W:0]   rd_p;
    logic             grant, expire;
    desc_t            d;
    cmd_t             cmd_q;

    assign d = '{addr: msg_addr_i, rd: msg_rd_i, rev: msg_rev_i,
                 nostart: msg_nostart_i, ignak: msg_ignak_i, len: msg_len_i};
    assign last       = ({1'b0, cur} == (msg_count_i - CNT_W'(1)));
    assign final_byte = last && ({1'b0, ptr} == ({1'b0, d.len} - 1'b1));
    assign rd_p       = (state == S_READ) ? ({1'b0, ptr} + 1'b1) : {1'b0, ptr};

    i2c_seq_arb #(.POLL_N(POLL_N), .RETRY_N(RETRY_N)) u_arb (
        .clk(clk), .rst(rst), .kick(go_i && state == S_IDLE),
        .busy(bus_busy_i), .grant(grant), .expire(expire)
    );

    always_comb begin
        st_n = state; cur_n = cur; ptr_n = ptr; err_n = err_q;
        iss = 1'b0; iss_kind = CMD_STOP; iss_ack = 1'b1;
        fin = 1'b0; fin_err = err_q; fin_cnt = '0;
        wstep = 1'b0; rstep = 1'b0; rd_we = 1'b0;
        unique case (state)
            S_IDLE: if (go_i) begin
                st_n = S_ARB; cur_n = '0; ptr_n = '0; err_n = ERR_NONE;
            end
            S_ARB: begin
                if (expire) begin
                    fin = 1'b1; fin_err = ERR_TIMEOUT; st_n = S_IDLE;
                end else if (grant) begin
                    iss = 1'b1; iss_kind = CMD_START; st_n = S_START;
                end
            end
            S_START: if (eng_done_i) begin
                if (eng_nak_i && !d.ignak) begin
                    err_n = ERR_REMOTE; st_n = S_STOP;
                end else if (last && d.len == '0) begin
                    st_n = S_STOP;
                end else if (d.rd) rstep = 1'b1;
                else               wstep = 1'b1;
            end
            S_WRITE: if (eng_done_i) wstep = 1'b1;
            S_READ: if (eng_done_i) begin
                if (eng_nak_i && !d.ignak && !final_byte) begin
                    err_n = ERR_REFUSED; st_n = S_STOP;
                end else begin
                    rd_we = 1'b1; rstep = 1'b1;
                end
            end
            S_NEXT: begin
                if (d.nostart) begin
                    if (d.rd) begin err_n = ERR_INVAL; st_n = S_STOP; end
                    else wstep = 1'b1;
                end else begin
                    iss = 1'b1; iss_kind = CMD_START; st_n = S_START;
                end
            end
            S_STOP: begin
                iss = 1'b1; iss_kind = CMD_STOP; fin = 1'b1; st_n = S_IDLE;
                fin_cnt = (err_q == ERR_NONE) ? ({1'b0, cur} + 1'b1) : {1'b0, cur};
            end
            default: st_n = S_IDLE;
        endcase

        if (wstep) begin
            if (ptr < d.len) begin
                iss = 1'b1; iss_kind = CMD_WRITE; ptr_n = ptr + 1'b1; st_n = S_WRITE;
            end else if (!last) begin
                cur_n = cur + 1'b1; ptr_n = '0; st_n = S_NEXT;
            end else st_n = S_STOP;
        end
        if (rstep) begin
            if (rd_p < {1'b0, d.len}) begin
                iss = 1'b1; iss_kind = CMD_READ; ptr_n = rd_p[LEN_W-1:0]; st_n = S_READ;
                iss_ack = !(last && rd_p == ({1'b0, d.len} - 1'b1));
            end else if (!last) begin
                cur_n = cur + 1'b1; ptr_n = '0; st_n = S_NEXT;
            end else st_n = S_STOP;
        end
    end

    i2c_seq_cmd u_cmd (
        .clk(clk), .rst(rst), .issue(iss), .kind(iss_kind), .desc(d),
        .wdata(wr_byte_i), .ack(iss_ack), .cmd_q(cmd_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE; cur <= '0; ptr <= '0; err_q <= ERR_NONE;
            done_q <= 1'b0; res_err <= ERR_NONE; res_cnt <= '0;
        end else begin
            state <= st_n; cur <= cur_n; ptr <= ptr_n; err_q <= err_n;
            done_q <= fin;
            if (fin) begin res_err <= fin_err; res_cnt <= fin_cnt; end
        end
    end

    assign msg_sel_o       = cur;
    assign byte_ptr_o      = ptr;
    assign rd_we_o         = rd_we;
    assign rd_byte_o       = eng_rx_i;
    assign eng_cmd_valid_o = cmd_q.vld;
    assign eng_cmd_o       = cmd_q.kind;
    assign eng_byte_o      = cmd_q.data;
    assign eng_ack_o       = cmd_q.ack;
    assign xfer_done_o     = done_q;
    assign xfer_err_o      = res_err;
    assign xfer_count_o    = res_cnt;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_done_o |=> !xfer_done_o); // R9
    AST_DONE_WITH_STOP: assert property (@(posedge clk) disable iff (rst)
        (xfer_done_o && xfer_err_o != ERR_TIMEOUT) |-> (eng_cmd_valid_o && eng_cmd_o == CMD_STOP)); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && $past(state) == S_IDLE) |-> !eng_cmd_valid_o); // R10
    AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid_o && eng_cmd_o == CMD_START && $past(state) == S_ARB) |-> !$past(bus_busy_i)); // R8
    AST_ADDR_BYTE: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid_o && eng_cmd_o == CMD_START) |-> (eng_byte_o[7:1] == msg_addr_i)); // R1
    AST_READ_ACK: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid_o && eng_cmd_o == CMD_READ) |-> (eng_ack_o == !final_byte)); // R6

endmodule

// File: tb/tb_i2c_msg_seq.sv
module tb_i2c_msg_seq;
    localparam int MSG_N = 8;
    localparam int IDX_W = $clog2(MSG_N);
    localparam int CNT_W = IDX_W + 1;

    typedef struct packed {
        logic [1:0]        n;
        logic [0:2][14:0]  m;
        logic [7:0]        nak;
        logic [2:0]        err;
        logic [3:0]        cnt;
        logic [4:0]        ncmd;
    } vec_t;

    // descriptor: {addr[6:0], rd, rev, nostart, ignak, len[3:0]}
    localparam vec_t VT [12] = '{
        '{2'd1, '{15'h5002, 15'h0000, 15'h0000}, 8'h00, 3'd0, 4'd1, 5'd4}, // R4 plain write
        '{2'd2, '{15'h5001, 15'h5082, 15'h0000}, 8'h00, 3'd0, 4'd2, 5'd6}, // R4 write then read
        '{2'd1, '{15'h3A00, 15'h0000, 15'h0000}, 8'h00, 3'd0, 4'd1, 5'd2}, // R3 probe
        '{2'd1, '{15'h3A00, 15'h0000, 15'h0000}, 8'h01, 3'd1, 4'd0, 5'd2}, // R2 addr nak
        '{2'd1, '{15'h2211, 15'h0000, 15'h0000}, 8'h01, 3'd0, 4'd1, 5'd3}, // R2 tolerated
        '{2'd2, '{15'h5001, 15'h5022, 15'h0000}, 8'h00, 3'd0, 4'd2, 5'd5}, // R5 continue
        '{2'd2, '{15'h5001, 15'h50A1, 15'h0000}, 8'h00, 3'd3, 4'd1, 5'd3}, // R5 reject
        '{2'd1, '{15'h6083, 15'h0000, 15'h0000}, 8'h02, 3'd2, 4'd0, 5'd3}, // R7 read nak
        '{2'd1, '{15'h6082, 15'h0000, 15'h0000}, 8'h04, 3'd0, 4'd1, 5'd4}, // R7 final nak ok
        '{2'd1, '{15'h6093, 15'h0000, 15'h0000}, 8'h02, 3'd0, 4'd1, 5'd5}, // R7 tolerated
        '{2'd3, '{15'h1101, 15'h1201, 15'h1381}, 8'h00, 3'd0, 4'd3, 5'd7}, // R4 three
        '{2'd2, '{15'h4400, 15'h4401, 15'h0000}, 8'h00, 3'd0, 4'd2, 5'd4}  // R3 empty not last
    };

    logic clk = 1'b0, rst = 1'b1, go = 1'b0;
    always #2.5 clk = ~clk;

    logic [CNT_W-1:0] msg_count;
    logic             bus_busy;
    logic [IDX_W-1:0] msg_sel;
    logic [3:0]       byte_ptr;
    logic [6:0]       m_addr;
    logic             m_rd, m_rev, m_ns, m_ign;
    logic [3:0]       m_len;
    logic [7:0]       wr_byte, rd_byte, eng_byte, eng_rx;
    logic             rd_we, cmd_v, eng_ack, eng_done, eng_nak, xdone;
    logic [1:0]       eng_cmd;
    logic [2:0]       xerr;
    logic [CNT_W-1:0] xcnt;

    logic [0:7][14:0] cur_m = '0;
    logic [7:0]       nak_mask = '0;
    logic [3:0]       run_tag = '0;
    logic             inj = 1'b0;
    int               cyc = 0, busy_until = 0;
    int               n_chk = 0, n_fail = 0;

    logic [1:0] log_kind [32];
    logic [7:0] log_byte [32];
    logic       log_ack  [32];
    logic [4:0] log_n;
    logic [7:0] rdmem [128];
    logic [2:0] wait_cnt;
    logic [3:0] ev;
    logic       mdl_done, mdl_nak;
    logic [7:0] mdl_rx;

    assign {m_addr, m_rd, m_rev, m_ns, m_ign, m_len} = cur_m[msg_sel];
    assign wr_byte  = 8'h40 + {1'b0, msg_sel, byte_ptr};
    assign bus_busy = (cyc < busy_until);
    assign eng_done = mdl_done | inj;
    assign eng_nak  = mdl_nak | inj;
    assign eng_rx   = mdl_rx;

    i2c_msg_seq #(.MSG_N(MSG_N)) dut (
        .clk(clk), .rst(rst), .go_i(go), .msg_count_i(msg_count), .bus_busy_i(bus_busy),
        .msg_sel_o(msg_sel), .byte_ptr_o(byte_ptr), .msg_addr_i(m_addr), .msg_rd_i(m_rd),
        .msg_rev_i(m_rev), .msg_nostart_i(m_ns), .msg_ignak_i(m_ign), .msg_len_i(m_len),
        .wr_byte_i(wr_byte), .rd_we_o(rd_we), .rd_byte_o(rd_byte),
        .eng_cmd_valid_o(cmd_v), .eng_cmd_o(eng_cmd), .eng_byte_o(eng_byte), .eng_ack_o(eng_ack),
        .eng_done_i(eng_done), .eng_nak_i(eng_nak), .eng_rx_i(eng_rx),
        .xfer_done_o(xdone), .xfer_err_o(xerr), .xfer_count_o(xcnt)
    );

    // byte engine model: completes each command three cycles after it appears
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            wait_cnt <= '0; mdl_done <= 1'b0; mdl_nak <= 1'b0; mdl_rx <= '0;
            ev <= '0; log_n <= '0;
        end else begin
            mdl_done <= 1'b0; mdl_nak <= 1'b0;
            if (go) begin ev <= '0; log_n <= '0; end
            if (cmd_v) begin
                log_kind[log_n] <= eng_cmd; log_byte[log_n] <= eng_byte;
                log_ack[log_n] <= eng_ack; log_n <= log_n + 1'b1; wait_cnt <= 3'd3;
            end else if (wait_cnt != 0) begin
                wait_cnt <= wait_cnt - 1'b1;
                if (wait_cnt == 3'd1) begin
                    mdl_done <= 1'b1; mdl_nak <= nak_mask[ev[2:0]];
                    mdl_rx <= {run_tag, ev}; ev <= ev + 1'b1;
                end
            end
            if (rd_we) rdmem[{msg_sel, byte_ptr}] <= rd_byte;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    int got_err, got_cnt, got_cyc;

    task automatic run_xfer(input logic [1:0] n, input logic [0:2][14:0] m, input logic [7:0] nk);
        @(negedge clk);
        cur_m = '0; cur_m[0] = m[0]; cur_m[1] = m[1]; cur_m[2] = m[2];
        msg_count = CNT_W'(n); nak_mask = nk; run_tag = run_tag + 1'b1;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        got_cyc = 1;
        got_err = -1; got_cnt = -1;
        for (int i = 0; i < 3000; i++) begin
            if (xdone) begin got_err = int'(xerr); got_cnt = int'(xcnt); break; end
            @(negedge clk);
            got_cyc++;
        end
        if (got_err < 0) check("R9 done never seen", 0, 1);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        int t0;
        msg_count = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset done", int'(xdone), 0);
        check("R10 reset cmd", int'(cmd_v), 0);
        rst = 1'b0;
        @(negedge clk);

        foreach (VT[i]) begin
            run_xfer(VT[i].n, VT[i].m, VT[i].nak);
            check($sformatf("R2 R3 R4 R5 R7 vec%0d err", i), got_err, int'(VT[i].err));
            check($sformatf("R4 vec%0d count", i), got_cnt, int'(VT[i].cnt));
            check($sformatf("R9 vec%0d ncmd", i), int'(log_n), int'(VT[i].ncmd));
            check($sformatf("R9 vec%0d last is stop", i), int'(log_kind[log_n - 1'b1]), 3);
            if (i == 5) check("R5 continue has no second start", int'(log_kind[2]), 1);
            if (i == 1) check("R4 repeated start", int'(log_kind[2]), 0);
        end

        // R1 address byte with inversion, and read address
        run_xfer(2'd1, '{15'h2D40, 15'h0, 15'h0}, 8'h00);
        check("R1 inverted write addr", int'(log_byte[0]), 8'h5B);
        run_xfer(2'd1, '{15'h50C1, 15'h0, 15'h0}, 8'h00);
        check("R1 inverted read addr", int'(log_byte[0]), 8'hA0);
        run_xfer(2'd2, '{15'h5001, 15'h5081, 15'h0}, 8'h00);
        check("R1 read addr", int'(log_byte[2]), 8'hA1);
        check("R1 write data", int'(log_byte[1]), 8'h40);

        // R6 ack pattern, R11 stored bytes
        run_xfer(2'd2, '{15'h5081, 15'h5182, 15'h0}, 8'h00);
        check("R6 ack non-last msg", int'(log_ack[1]), 1);
        check("R6 ack mid byte", int'(log_ack[3]), 1);
        check("R6 nak final byte", int'(log_ack[4]), 0);
        check("R11 msg0 byte0", int'(rdmem[{3'd0, 4'd0}]), int'({run_tag, 4'd1}));
        check("R11 msg1 byte1", int'(rdmem[{3'd1, 4'd1}]), int'({run_tag, 4'd4}));

        // R8 timeout with bus held busy
        busy_until = cyc + 100000;
        run_xfer(2'd1, '{15'h5002, 15'h0, 15'h0}, 8'h00);
        check("R8 timeout err", got_err, 4);
        check("R8 timeout count", got_cnt, 0);
        check("R8 no command", int'(log_n), 0);
        check("R8 window", int'(got_cyc >= 799 && got_cyc <= 803), 1);
        // R8 bus frees during the second attempt
        busy_until = cyc + 500;
        t0 = cyc;
        run_xfer(2'd1, '{15'h5002, 15'h0, 15'h0}, 8'h00);
        check("R8 retry success", got_err, 0);
        check("R8 start after busy", int'(got_cyc > 500), 1);
        busy_until = 0;

        // R10 stray completion while idle
        @(negedge clk); inj = 1'b1;
        @(negedge clk); inj = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                if (cmd_v || xdone) seen++;
                @(negedge clk);
            end
            check("R10 idle event ignored", seen, 0);
        end
        run_xfer(2'd1, '{15'h5002, 15'h0, 15'h0}, 8'h00);
        check("R10 next xfer err", got_err, 0);
        check("R10 next xfer ncmd", int'(log_n), 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule